// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing fields of a memory operand into a 32-bit linear address. An optional base register value, an optional index register value scaled by 1, 2, 4 or 8, and a signed displacement of 8 or 32 bits are summed into an offset. A segment is picked either from the kind of reference (data, code flow or stack) or from an explicit override code. Its base is added to the offset, and the offset is compared with that segment's limit.

Six segment descriptor caches sit inside the block. Each cache holds a selector, a base and a limit, and a write port loads them. Each request is taken in one cycle. The linear address, the limit-fault flag and the selector of the segment that was used appear on the registered outputs in the next cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: The offset is (baseVal if baseUse else 0) + (indexVal scaled if indexUse else 0) + displacement, taken modulo 2^32.
- R2: scaleCode 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: With dispWide=1 all 32 bits of disp are the displacement. With dispWide=0 only disp[7:0] is used, sign-extended, and disp[31:8] has no effect.
- R4: Segment codes are 0=CS, 1=SS, 2=DS, 3=ES, 4=FS, 5=GS. Without an override, refClass 1 (code flow) uses CS, refClass 2 (stack) uses SS, and refClass 0 or 3 (data) uses DS.
- R5: When ovrUse=1 and ovrSeg is 0..5, the segment ovrSeg is used in place of the implicit one. Override codes 6 and 7 are ignored, and the implicit segment is used.
- R6: linAddr equals the chosen segment's base plus the offset, modulo 2^32.
- R7: limitFault is 1 exactly when the offset, as an unsigned value, is greater than the chosen segment's limit. An offset equal to the limit does not fault.
- R8: outValid is high in the cycle after reqValid was high, and low otherwise. linAddr, limitFault and segSelOut change only after an accepted request and hold otherwise.
- R9: A write (wrEn, wrSeg 0..5) loads the selector, base and limit at the clock edge. A request in the same cycle still sees the old contents, and requests in later cycles see the new ones. wrSeg codes 6 and 7 change nothing.
- R10: After reset every cache holds selector 0, base 0 and limit 0xFFFFFFFF, and outValid, linAddr, limitFault and segSelOut are 0.
- R11: segSelOut gives the selector of the segment that the request used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| baseUse | input | 1 | Base term is present |
| baseVal | input | 32 | Base register value |
| indexUse | input | 1 | Index term is present |
| indexVal | input | 32 | Index register value |
| scaleCode | input | 2 | Index scale code: 1 shifted left by this value |
| disp | input | 32 | Displacement |
| dispWide | input | 1 | 1: 32-bit displacement, 0: 8-bit sign-extended |
| refClass | input | 2 | Reference kind: 0 data, 1 code flow, 2 stack, 3 data |
| ovrUse | input | 1 | Segment override present |
| ovrSeg | input | 3 | Override segment code |
| wrEn | input | 1 | Descriptor cache write strobe |
| wrSeg | input | 3 | Segment code to load |
| wrSelector | input | 16 | Selector to load |
| wrBase | input | 32 | Base to load |
| wrLimit | input | 32 | Limit to load |
| outValid | output | 1 | Result is valid |
| linAddr | output | 32 | Linear address |
| limitFault | output | 1 | Offset exceeds the segment limit |
| segSelOut | output | 16 | Selector of the segment used |

## Verification
The assertions assume that the request fields are known whenever reqValid is high. They also assume that a request with no base, no index and a zero displacement has an offset of zero, which must never fault whatever limit is loaded. The stimulus changes every input at the falling edge only and holds each request's fields stable through the following rising edge. Out-of-range override and write codes are applied on purpose, but only together with a defined implicit segment, so the expected result stays well defined.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NUM_SEG  = 6;
  localparam int SEG_BITS = 3;

  typedef enum logic [SEG_BITS-1:0] {
    SEG_CODE  = 3'd0,
    SEG_STACK = 3'd1,
    SEG_DATA  = 3'd2,
    SEG_EXTRA = 3'd3,
    SEG_AUXF  = 3'd4,
    SEG_AUXG  = 3'd5
  } segId_t;

  typedef enum logic [1:0] {
    REF_DATA  = 2'd0,
    REF_FLOW  = 2'd1,
    REF_STACK = 2'd2,
    REF_OTHER = 2'd3
  } refKind_t;

  typedef struct packed {
    logic   capture;
    logic   load;
    segId_t useSeg;
    segId_t loadSeg;
  } ctrlStrobe_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic                reqValid,
  input  logic [1:0]          refClass,
  input  logic                ovrUse,
  input  logic [SEG_BITS-1:0] ovrSeg,
  input  logic                wrEn,
  input  logic [SEG_BITS-1:0] wrSeg,
  output ctrlStrobe_t         strobe
);
  localparam logic [SEG_BITS-1:0] SegCount = SEG_BITS'(NUM_SEG);

  segId_t implicitSeg;
  logic   ovrOk;
  logic   wrOk;

  // Reference kind picks the default segment
  always_comb begin
    unique case (refKind_t'(refClass))
      REF_FLOW:  implicitSeg = SEG_CODE;
      REF_STACK: implicitSeg = SEG_STACK;
      default:   implicitSeg = SEG_DATA;
    endcase
  end

  assign ovrOk = ovrUse && (ovrSeg < SegCount);
  assign wrOk  = wrEn && (wrSeg < SegCount);

  always_comb begin
    strobe.capture = reqValid;
    strobe.load    = wrOk;
    strobe.useSeg  = ovrOk ? segId_t'(ovrSeg) : implicitSeg;
    strobe.loadSeg = wrOk ? segId_t'(wrSeg) : SEG_CODE;
  end
endmodule

// File: rtl/seg_addr_dpath.sv
module seg_addr_dpath
  import seg_addr_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int DW_NARROW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              baseUse,
  input  logic [AW-1:0]     baseVal,
  input  logic              indexUse,
  input  logic [AW-1:0]     indexVal,
  input  logic [1:0]        scaleCode,
  input  logic [AW-1:0]     disp,
  input  logic              dispWide,
  input  logic [SW-1:0]     wrSelector,
  input  logic [AW-1:0]     wrBase,
  input  logic [AW-1:0]     wrLimit,
  output logic              outValid,
  output logic [AW-1:0]     linAddr,
  output logic              limitFault,
  output logic [SW-1:0]     segSelOut
);
  localparam int EXT_BITS = AW - DW_NARROW;

  logic [SW-1:0] selQ   [NUM_SEG];
  logic [AW-1:0] baseQ  [NUM_SEG];
  logic [AW-1:0] limitQ [NUM_SEG];

  // Descriptor caches, one per segment
  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ[g]   <= '0;
        baseQ[g]  <= '0;
        limitQ[g] <= '1;
      end else if (strobe.load && (strobe.loadSeg == segId_t'(g))) begin
        selQ[g]   <= wrSelector;
        baseQ[g]  <= wrBase;
        limitQ[g] <= wrLimit;
      end
    end
  end

  logic [AW-1:0] baseTerm;
  logic [AW-1:0] idxTerm;
  logic [AW-1:0] dispTerm;
  logic [AW-1:0] offset;
  logic [AW-1:0] segBase;
  logic [AW-1:0] segLimit;
  logic [SW-1:0] segSel;

  assign baseTerm = baseUse ? baseVal : '0;
  assign idxTerm  = indexUse ? (indexVal << scaleCode) : '0;
  assign dispTerm = dispWide ? disp
                  : {{EXT_BITS{disp[DW_NARROW-1]}}, disp[DW_NARROW-1:0]};
  assign offset   = baseTerm + idxTerm + dispTerm;

  assign segBase  = baseQ[strobe.useSeg];
  assign segLimit = limitQ[strobe.useSeg];
  assign segSel   = selQ[strobe.useSeg];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      linAddr    <= '0;
      limitFault <= 1'b0;
      segSelOut  <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        linAddr    <= segBase + offset;
        limitFault <= offset > segLimit;
        segSelOut  <= segSel;
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                baseUse,
  input  logic [AW-1:0]       baseVal,
  input  logic                indexUse,
  input  logic [AW-1:0]       indexVal,
  input  logic [1:0]          scaleCode,
  input  logic [AW-1:0]       disp,
  input  logic                dispWide,
  input  logic [1:0]          refClass,
  input  logic                ovrUse,
  input  logic [SEG_BITS-1:0] ovrSeg,
  input  logic                wrEn,
  input  logic [SEG_BITS-1:0] wrSeg,
  input  logic [SW-1:0]       wrSelector,
  input  logic [AW-1:0]       wrBase,
  input  logic [AW-1:0]       wrLimit,
  output logic                outValid,
  output logic [AW-1:0]       linAddr,
  output logic                limitFault,
  output logic [SW-1:0]       segSelOut
);
  ctrlStrobe_t strobe;

  seg_addr_ctrl uCtrl (
    .reqValid (reqValid),
    .refClass (refClass),
    .ovrUse   (ovrUse),
    .ovrSeg   (ovrSeg),
    .wrEn     (wrEn),
    .wrSeg    (wrSeg),
    .strobe   (strobe)
  );

  seg_addr_dpath #(.AW(AW), .SW(SW)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseUse    (baseUse),
    .baseVal    (baseVal),
    .indexUse   (indexUse),
    .indexVal   (indexVal),
    .scaleCode  (scaleCode),
    .disp       (disp),
    .dispWide   (dispWide),
    .wrSelector (wrSelector),
    .wrBase     (wrBase),
    .wrLimit    (wrLimit),
    .outValid   (outValid),
    .linAddr    (linAddr),
    .limitFault (limitFault),
    .segSelOut  (segSelOut)
  );
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          baseUse,
  input logic          indexUse,
  input logic [AW-1:0] disp,
  input logic          dispWide,
  input logic          outValid,
  input logic [AW-1:0] linAddr,
  input logic          limitFault,
  input logic [SW-1:0] segSelOut
);
  logic zeroOffset;
  assign zeroOffset = !baseUse && !indexUse &&
                      (dispWide ? (disp == '0) : (disp[7:0] == 8'd0));

  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(linAddr) && $stable(limitFault) && $stable(segSelOut)));

  // R7
  zero_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && zeroOffset) |=> !limitFault);
endmodule

bind seg_addr_gen seg_addr_chk #(.AW(AW), .SW(SW)) uChk (.*);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, baseUse = 1'b0, indexUse = 1'b0, dispWide = 1'b0;
  logic [31:0] baseVal = '0, indexVal = '0, disp = '0;
  logic [1:0]  scaleCode = '0, refClass = '0;
  logic        ovrUse = 1'b0, wrEn = 1'b0;
  logic [2:0]  ovrSeg = '0, wrSeg = '0;
  logic [15:0] wrSelector = '0;
  logic [31:0] wrBase = '0, wrLimit = '0;
  logic        outValid, limitFault;
  logic [31:0] linAddr;
  logic [15:0] segSelOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u0 (.*);

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [31:0] addr;
    logic        fault;
    logic [15:0] sel;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  expItem_t lastExp;

  logic [15:0] mSel [6];
  logic [31:0] mBase[6];
  logic [31:0] mLim [6];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare each produced result
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected outValid", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(linAddr == e.addr, {t, " addr"}, linAddr, e.addr);
        check(limitFault == e.fault, {t, " fault"}, 32'(limitFault), 32'(e.fault));
        check(segSelOut == e.sel, {t, " R11 sel"}, 32'(segSelOut), 32'(e.sel));
      end
    end
  end

  // Driver: compute expectation from model, push, apply for one cycle
  task automatic req(input logic bu, input logic [31:0] b, input logic iu,
                     input logic [31:0] ix, input logic [1:0] sc,
                     input logic [31:0] d, input logic dw, input logic [1:0] cls,
                     input logic ou, input logic [2:0] os, input string tag);
    logic [31:0] off;
    int seg;
    expItem_t e;
    off = (bu ? b : 32'd0) + (iu ? (ix << sc) : 32'd0)
        + (dw ? d : {{24{d[7]}}, d[7:0]});
    if (ou && os < 3'd6) seg = int'(os);
    else if (cls == 2'd1) seg = 0;
    else if (cls == 2'd2) seg = 1;
    else seg = 2;
    e.addr  = mBase[seg] + off;
    e.fault = off > mLim[seg];
    e.sel   = mSel[seg];
    expQ.push_back(e);
    tagQ.push_back(tag);
    lastExp = e;
    reqValid = 1'b1; baseUse = bu; baseVal = b; indexUse = iu; indexVal = ix;
    scaleCode = sc; disp = d; dispWide = dw; refClass = cls; ovrUse = ou; ovrSeg = os;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; wrEn = 1'b0;
  endtask

  task automatic loadSeg(input logic [2:0] s, input logic [15:0] sel,
                         input logic [31:0] b, input logic [31:0] l);
    wrEn = 1'b1; wrSeg = s; wrSelector = sel; wrBase = b; wrLimit = l;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    if (s < 3'd6) begin
      mSel[s] = sel; mBase[s] = b; mLim[s] = l;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      mSel[i] = '0; mBase[i] = '0; mLim[i] = '1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(outValid == 1'b0, "R10 outValid", 32'(outValid), 32'd0);
    check(linAddr == 32'd0, "R10 linAddr", linAddr, 32'd0);
    check(limitFault == 1'b0, "R10 limitFault", 32'(limitFault), 32'd0);
    check(segSelOut == 16'd0, "R10 segSelOut", 32'(segSelOut), 32'd0);
    // R10 flat caches after reset
    req(1, 32'hFFFF_0000, 0, 0, 0, 32'h0000_1234, 1, 0, 0, 0, "R10 flat DS");
    req(0, 0, 0, 0, 0, 32'hFFFF_FFFF, 1, 1, 0, 0, "R10 flat CS max");

    loadSeg(3'd0, 16'h0008, 32'h1000_0000, 32'h0000_FFFF);
    loadSeg(3'd1, 16'h0010, 32'h2000_0000, 32'h0000_0FFF);
    loadSeg(3'd2, 16'h0018, 32'h3000_0000, 32'h000F_FFFF);
    loadSeg(3'd3, 16'h0020, 32'h4000_0000, 32'h0000_00FF);
    loadSeg(3'd4, 16'h0028, 32'h5000_0000, 32'h7FFF_FFFF);
    loadSeg(3'd5, 16'h0030, 32'h6000_0000, 32'h0000_1000);

    // R1 R2 all three terms, each scale
    for (int s = 0; s < 4; s++)
      req(1, 32'h0000_0100, 1, 32'h0000_0010, 2'(s), 32'h0000_0004, 1, 0, 0, 0, "R1 R2 scale");
    // R1 absent terms
    req(0, 32'hDEAD_BEEF, 1, 32'h20, 2'd3, 32'h0, 1, 0, 0, 0, "R1 no base");
    req(1, 32'h40, 0, 32'hFFFF_FFFF, 2'd2, 32'h0, 1, 0, 0, 0, "R1 no index");
    // R3 narrow displacement sign-extended, upper bits ignored
    req(1, 32'h1000, 0, 0, 0, 32'hABCD_EF80, 0, 0, 0, 0, "R3 disp8 neg");
    req(1, 32'h1000, 0, 0, 0, 32'h5555_557F, 0, 0, 0, 0, "R3 disp8 pos");
    req(1, 32'h1000, 0, 0, 0, 32'hFFFF_FF00, 1, 0, 0, 0, "R3 disp32 neg");
    // R1 wrap modulo 2^32, R6 base add
    req(1, 32'hFFFF_FFF0, 0, 0, 0, 32'h20, 1, 0, 0, 0, "R1 R6 wrap");
    // R4 implicit choices
    req(1, 32'h10, 0, 0, 0, 0, 0, 1, 0, 0, "R4 flow CS");
    req(1, 32'h10, 0, 0, 0, 0, 0, 2, 0, 0, "R4 stack SS");
    req(1, 32'h10, 0, 0, 0, 0, 0, 3, 0, 0, "R4 other DS");
    // R5 overrides of each segment and ignored codes
    for (int s = 0; s < 8; s++)
      req(1, 32'h20, 0, 0, 0, 0, 0, 2, 1, 3'(s), "R5 override");
    // R7 limit boundaries
    req(0, 0, 0, 0, 0, 32'h0000_0FFF, 1, 2, 0, 0, "R7 at limit");
    req(0, 0, 0, 0, 0, 32'h0000_1000, 1, 2, 0, 0, "R7 limit+1");
    req(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 1, 3'd4, "R7 unsigned huge");
    // R9 ignored write code
    loadSeg(3'd7, 16'hBEEF, 32'h7777_0000, 32'h0);
    req(1, 32'h30, 0, 0, 0, 0, 0, 0, 0, 0, "R9 wrSeg 7 no effect");
    // R9 same-cycle write sees old, next sees new
    wrEn = 1'b1; wrSeg = 3'd2; wrSelector = 16'h0099; wrBase = 32'h0A00_0000; wrLimit = 32'h10;
    req(1, 32'h30, 0, 0, 0, 0, 0, 0, 0, 0, "R9 same cycle old");
    mSel[2] = 16'h0099; mBase[2] = 32'h0A00_0000; mLim[2] = 32'h10;
    req(1, 32'h30, 0, 0, 0, 0, 0, 0, 0, 0, "R9 next cycle new");
    // R8 hold while idle
    baseVal = 32'h1234_5678; disp = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 idle valid", 32'(outValid), 32'd0);
    check(linAddr == lastExp.addr, "R8 hold addr", linAddr, lastExp.addr);
    check(limitFault == lastExp.fault, "R8 hold fault", 32'(limitFault), 32'(lastExp.fault));
    check(expQ.size() == 0, "R8 queue drained", 32'(expQ.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule